// File: doc/BRIEF.md
# Decode-Stage Hazard Stall Unit

This block sits beside the decode stage of a five-stage in-order pipeline whose branches compare registers and resolve in decode. It looks at the two source registers of the decoding instruction, whether that instruction is a branch, and the destination, memory-read and register-write information of the instructions now in execute and in memory. From these it decides whether the decoding instruction must wait because forwarding cannot yet deliver its operand.

When it must wait, the unit freezes the program counter and the fetch/decode register, so the same instruction is decoded again and the same successor is fetched again. It also asks for a bubble, so that all-zero control fields enter the decode/execute register and the execute, memory and writeback stages do no work that cycle. The unit is purely combinational. A stall that lasts two cycles is not counted by any state: the condition is evaluated again each cycle as the producing load moves down the pipeline.

Three situations cause a stall. The first is an ALU-type instruction that needs a load result one cycle early. The second is a branch that needs a value the instruction directly ahead is still computing in execute. The third is a branch that needs a load result while that load is still in the memory stage. Forwarding already covers every other ordering, and those orderings pass without delay.

Top module: `decode_hazard_stall`

## Requirements
- R1: When the execute-stage instruction reads memory, writes a register, and its destination (nonzero) equals the decode-stage rs or rt, the unit stalls in that same cycle: pc_we=0, ifid_we=0, idex_bubble=1. This holds whether or not the decode instruction is a branch.
- R2: At all times pc_we equals ifid_we, and idex_bubble is their inverse. Stall means pc_we=0, ifid_we=0, idex_bubble=1. Proceed means pc_we=1, ifid_we=1, idex_bubble=0.
- R3: When the decode instruction is a branch (id_branch=1) and the execute-stage instruction writes a register whose nonzero destination equals rs or rt, the unit stalls. This covers a dependence on the directly preceding ALU instruction.
- R4: When the decode instruction is a branch and the memory-stage instruction is a register-writing load whose nonzero destination equals rs or rt, the unit stalls. This covers a dependence on a load two instructions earlier.
- R5: A branch that depends on the directly preceding load stalls for exactly two consecutive cycles. In the first cycle the load is in execute. In the second the load is in memory and execute holds a bubble. In the third cycle the load has left memory and the branch proceeds.
- R6: A branch whose only producers are ALU instructions in the memory stage, or further back, proceeds without a stall.
- R7: A destination register index of 0 never causes a stall, whatever the other inputs are.
- R8: A non-branch decode instruction proceeds when its producer is an ALU instruction in execute, or a load in memory.
- R9: An execute-stage instruction that neither writes a register nor reads memory never causes a stall, even if its destination field equals a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 5 | First source register index of the decoding instruction |
| id_rt | input | 5 | Second source register index of the decoding instruction |
| id_branch | input | 1 | Decoding instruction is a register-comparing branch |
| ex_rd | input | 5 | Destination register index of the execute-stage instruction |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| mem_rd | input | 5 | Destination register index of the memory-stage instruction |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| pc_we | output | 1 | Program counter may advance |
| ifid_we | output | 1 | Fetch/decode register may load |
| idex_bubble | output | 1 | Force zero control fields into decode/execute |

## Verification
Every result of this unit is due in the same cycle as the stimulus that causes it, because no register lies between the inputs and the three outputs. The driver changes inputs on the falling edge and queues the expected stall decision. The monitor compares each queued item 1 ns later, well before the next rising edge, so each comparison sees only the stage contents of its own cycle. The two-cycle branch stall is driven as three back-to-back cycles that mirror a load advancing from execute to memory and then out. One queued item is checked per cycle, so a stall that ends early or runs long shows up in the right cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Width of a register index.
  localparam int REG_AW = 5;
  // Number of source operands examined in decode.
  localparam int N_SRC  = 2;

  typedef logic [REG_AW-1:0] reg_idx_t;

  // Reason the decode stage is held; priority follows the enum order.
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_LOAD_USE = 2'd1,
    CAUSE_BR_EX    = 2'd2,
    CAUSE_BR_MEM   = 2'd3
  } stall_cause_t;

  // Index 0 is hard-wired and never carries a live value.
  function automatic logic idx_is_live(input reg_idx_t idx);
    return idx != '0;
  endfunction

  // True when a producer destination feeds a consumer source.
  function automatic logic feeds(input reg_idx_t dst, input reg_idx_t src);
    return idx_is_live(dst) && (dst == src);
  endfunction

endpackage

// File: rtl/hz_dest_match.sv
module hz_dest_match
  import hz_pkg::*;
(
  input  reg_idx_t dst,
  input  reg_idx_t src_a,
  input  reg_idx_t src_b,
  output logic     hit
);
  reg_idx_t          srcs [N_SRC];
  logic [N_SRC-1:0]  per_src;

  assign srcs[0] = src_a;
  assign srcs[1] = src_b;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign per_src[g] = feeds(dst, srcs[g]);
  end

  assign hit = |per_src;
endmodule

// File: rtl/hz_stall_cause.sv
module hz_stall_cause
  import hz_pkg::*;
(
  input  logic         id_branch,
  input  logic         ex_hit,
  input  logic         ex_mem_read,
  input  logic         ex_reg_write,
  input  logic         mem_hit,
  input  logic         mem_mem_read,
  input  logic         mem_reg_write,
  output logic         load_use_hit,
  output logic         br_ex_hit,
  output logic         br_mem_hit,
  output stall_cause_t cause
);
  // A load one stage ahead cannot be forwarded in time for anyone.
  assign load_use_hit = ex_hit && ex_mem_read && ex_reg_write;
  // A branch compares in decode, so any result still in execute is late.
  assign br_ex_hit    = id_branch && ex_hit && ex_reg_write;
  // A load in memory has no data until the end of that stage.
  assign br_mem_hit   = id_branch && mem_hit && mem_mem_read && mem_reg_write;

  always_comb begin
    if (load_use_hit)    cause = CAUSE_LOAD_USE;
    else if (br_ex_hit)  cause = CAUSE_BR_EX;
    else if (br_mem_hit) cause = CAUSE_BR_MEM;
    else                 cause = CAUSE_NONE;
  end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
(
  input  stall_cause_t cause,
  output logic         pc_we,
  output logic         ifid_we,
  output logic         idex_bubble
);
  logic hold;

  assign hold        = (cause != CAUSE_NONE);
  assign pc_we       = !hold;
  assign ifid_we     = !hold;
  assign idex_bubble = hold;
endmodule

// File: rtl/decode_hazard_stall.sv
module decode_hazard_stall
  import hz_pkg::*;
(
  input  logic [hz_pkg::REG_AW-1:0] id_rs,
  input  logic [hz_pkg::REG_AW-1:0] id_rt,
  input  logic                      id_branch,
  input  logic [hz_pkg::REG_AW-1:0] ex_rd,
  input  logic                      ex_mem_read,
  input  logic                      ex_reg_write,
  input  logic [hz_pkg::REG_AW-1:0] mem_rd,
  input  logic                      mem_mem_read,
  input  logic                      mem_reg_write,
  output logic                      pc_we,
  output logic                      ifid_we,
  output logic                      idex_bubble
);
  // Internal events, named for the checker.
  logic         ex_hit;
  logic         mem_hit;
  logic         load_use_hit;
  logic         br_ex_hit;
  logic         br_mem_hit;
  stall_cause_t cause;

  hz_dest_match u_ex_match (
    .dst(ex_rd), .src_a(id_rs), .src_b(id_rt), .hit(ex_hit)
  );

  hz_dest_match u_mem_match (
    .dst(mem_rd), .src_a(id_rs), .src_b(id_rt), .hit(mem_hit)
  );

  hz_stall_cause u_cause (
    .id_branch    (id_branch),
    .ex_hit       (ex_hit),
    .ex_mem_read  (ex_mem_read),
    .ex_reg_write (ex_reg_write),
    .mem_hit      (mem_hit),
    .mem_mem_read (mem_mem_read),
    .mem_reg_write(mem_reg_write),
    .load_use_hit (load_use_hit),
    .br_ex_hit    (br_ex_hit),
    .br_mem_hit   (br_mem_hit),
    .cause        (cause)
  );

  hz_stall_ctrl u_ctrl (
    .cause      (cause),
    .pc_we      (pc_we),
    .ifid_we    (ifid_we),
    .idex_bubble(idex_bubble)
  );
endmodule

// File: rtl/decode_hazard_checker.sv
module decode_hazard_checker
  import hz_pkg::*;
(
  input logic [hz_pkg::REG_AW-1:0] id_rs,
  input logic [hz_pkg::REG_AW-1:0] id_rt,
  input logic                      id_branch,
  input logic [hz_pkg::REG_AW-1:0] ex_rd,
  input logic                      ex_mem_read,
  input logic                      ex_reg_write,
  input logic [hz_pkg::REG_AW-1:0] mem_rd,
  input logic                      mem_mem_read,
  input logic                      load_use_hit,
  input logic                      br_ex_hit,
  input logic                      br_mem_hit,
  input stall_cause_t              cause,
  input logic                      pc_we,
  input logic                      ifid_we,
  input logic                      idex_bubble
);
  logic src_ex_eq;

  assign src_ex_eq = (ex_rd == id_rs) || (ex_rd == id_rt);

  always_comb begin
    // R2
    p_hold_pair_r2: assert (pc_we == ifid_we && pc_we == !idex_bubble)
      else $error("stall outputs disagree");
    // R2
    p_cause_bubble_r2: assert ((cause != CAUSE_NONE) == idex_bubble)
      else $error("cause and bubble disagree");
    if (load_use_hit) begin
      // R1
      p_load_use_r1: assert (idex_bubble && !pc_we)
        else $error("load-use event without stall");
    end
    if (br_ex_hit) begin
      // R3
      p_branch_ex_r3: assert (idex_bubble && !ifid_we)
        else $error("branch/execute event without stall");
    end
    if (br_mem_hit) begin
      // R4
      p_branch_mem_r4: assert (idex_bubble)
        else $error("branch/memory-load event without stall");
    end
    if (ex_rd == '0 && mem_rd == '0) begin
      // R7
      p_zero_dest_r7: assert (!idex_bubble)
        else $error("stall with zero destinations");
    end
    if (!id_branch && !ex_mem_read) begin
      // R8
      p_nonbranch_fwd_r8: assert (pc_we)
        else $error("non-branch stalled without a load in execute");
    end
    if (id_branch && !ex_reg_write && !ex_mem_read && !mem_mem_read) begin
      // R6
      p_branch_fwd_r6: assert (pc_we)
        else $error("branch stalled on forwardable producer");
    end
    if (!ex_reg_write && !ex_mem_read && src_ex_eq && !mem_mem_read) begin
      // R9
      p_ex_idle_r9: assert (!idex_bubble)
        else $error("non-writing execute instruction stalled");
    end
  end
endmodule

bind decode_hazard_stall decode_hazard_checker u_chk (
  .id_rs       (id_rs),
  .id_rt       (id_rt),
  .id_branch   (id_branch),
  .ex_rd       (ex_rd),
  .ex_mem_read (ex_mem_read),
  .ex_reg_write(ex_reg_write),
  .mem_rd      (mem_rd),
  .mem_mem_read(mem_mem_read),
  .load_use_hit(load_use_hit),
  .br_ex_hit   (br_ex_hit),
  .br_mem_hit  (br_mem_hit),
  .cause       (cause),
  .pc_we       (pc_we),
  .ifid_we     (ifid_we),
  .idex_bubble (idex_bubble)
);

// File: tb/sim_decode_hazard_stall.sv
`timescale 1ns/100ps
module sim_decode_hazard_stall;

  logic       clk = 1'b0;
  logic [4:0] id_rs, id_rt, ex_rd, mem_rd;
  logic       id_branch, ex_mem_read, ex_reg_write, mem_mem_read, mem_reg_write;
  logic       pc_we, ifid_we, idex_bubble;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    bit    stall;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  decode_hazard_stall u0 (
    .id_rs(id_rs), .id_rt(id_rt), .id_branch(id_branch),
    .ex_rd(ex_rd), .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write),
    .mem_rd(mem_rd), .mem_mem_read(mem_mem_read), .mem_reg_write(mem_reg_write),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
  );

  // Independent restatement of the requirements: must decode wait?
  function automatic bit must_wait(
    input logic [4:0] rs, rt, input logic br,
    input logic [4:0] erd, input logic emr, erw,
    input logic [4:0] mrd, input logic mmr, mrw);
    bit uses_e, uses_m;
    uses_e = (erd != 0) && (rs == erd || rt == erd);
    uses_m = (mrd != 0) && (rs == mrd || rt == mrd);
    if (uses_e && emr && erw) return 1;        // R1
    if (br && uses_e && erw) return 1;         // R3
    if (br && uses_m && mmr && mrw) return 1;  // R4
    return 0;
  endfunction

  task automatic drive(
    input logic [4:0] rs, rt, input logic br,
    input logic [4:0] erd, input logic emr, erw,
    input logic [4:0] mrd, input logic mmr, mrw,
    input bit exp_stall, input string tag);
    exp_t e;
    @(negedge clk);
    id_rs = rs; id_rt = rt; id_branch = br;
    ex_rd = erd; ex_mem_read = emr; ex_reg_write = erw;
    mem_rd = mrd; mem_mem_read = mmr; mem_reg_write = mrw;
    e.stall = exp_stall;
    e.tag   = tag;
    sb.push_back(e);
  endtask

  // Monitor: one scoreboard item per cycle, sampled 1 ns after the drive.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        logic [2:0] act, exp3;
        e    = sb.pop_front();
        act  = {pc_we, ifid_we, idex_bubble};
        exp3 = e.stall ? 3'b001 : 3'b110;
        n_checks++;
        if (act !== exp3) begin
          n_fails++;
          $display("FAIL %s: {pc_we,ifid_we,bubble} actual=%b expected=%b", e.tag, act, exp3);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    id_rs = 0; id_rt = 0; id_branch = 0; ex_rd = 0; ex_mem_read = 0;
    ex_reg_write = 0; mem_rd = 0; mem_mem_read = 0; mem_reg_write = 0;

    // Idle pipeline: nothing to wait for (R2 proceed encoding).
    drive(0,0,0, 0,0,0, 0,0,0, 0, "R2 idle");
    // R1 load-use on rs, on rt, and for a branch.
    drive(3,4,0, 3,1,1, 0,0,0, 1, "R1 load rs");
    drive(3,4,0, 4,1,1, 0,0,0, 1, "R1 load rt");
    drive(7,2,1, 2,1,1, 0,0,0, 1, "R1 load branch");
    drive(3,4,0, 5,1,1, 0,0,0, 0, "R1 load no match");
    // R3 branch on the directly preceding ALU result.
    drive(6,9,1, 9,0,1, 0,0,0, 1, "R3 branch alu ex rt");
    drive(6,9,1, 6,0,1, 0,0,0, 1, "R3 branch alu ex rs");
    // R4 branch on a load two instructions back.
    drive(8,1,1, 0,0,0, 8,1,1, 1, "R4 branch load mem");
    drive(8,1,1, 12,0,1, 1,1,1, 1, "R4 branch load mem rt");
    // R5 two-cycle sequence as the load advances.
    drive(10,0,1, 10,1,1, 0,0,0, 1, "R5 cycle1 load in ex");
    drive(10,0,1, 0,0,0, 10,1,1, 1, "R5 cycle2 load in mem");
    drive(10,0,1, 0,0,0, 0,0,0, 0, "R5 cycle3 proceed");
    // R6 ALU producers in memory stage forward to branch.
    drive(11,12,1, 0,0,0, 11,0,1, 0, "R6 branch alu mem");
    drive(11,12,1, 13,0,1, 12,0,1, 0, "R6 branch alu mem rt");
    // R7 zero destination.
    drive(0,0,1, 0,1,1, 0,1,1, 0, "R7 zero dest all");
    drive(0,5,0, 0,1,1, 0,0,0, 0, "R7 zero load");
    // R8 non-branch forwarding cases.
    drive(14,15,0, 14,0,1, 0,0,0, 0, "R8 alu in ex");
    drive(14,15,0, 0,0,0, 15,1,1, 0, "R8 load in mem");
    // R9 execute instruction that writes nothing.
    drive(16,17,1, 16,0,0, 0,0,0, 0, "R9 nonwriting ex branch");
    drive(16,17,0, 17,0,0, 0,0,0, 0, "R9 nonwriting ex");

    // Mixed sweep over a small register range, using the bench model.
    for (int i = 0; i < 300; i++) begin
      logic [4:0] a, b, c, d;
      logic br, emr, erw, mmr, mrw;
      a = 5'($urandom_range(0, 3)); b = 5'($urandom_range(0, 3));
      c = 5'($urandom_range(0, 3)); d = 5'($urandom_range(0, 3));
      br = 1'($urandom_range(0, 1)); emr = 1'($urandom_range(0, 1));
      erw = 1'($urandom_range(0, 1)); mmr = 1'($urandom_range(0, 1));
      mrw = 1'($urandom_range(0, 1));
      drive(a, b, br, c, emr, erw, d, mmr, mrw,
            must_wait(a, b, br, c, emr, erw, d, mmr, mrw), "R1/R3/R4 sweep");
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule